// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host side of a three-wire link to a 12-bit differential successive-approximation converter. The link has an active-low chip select, a serial clock and one serial data line back to the host. The converter samples its input and starts converting at the instant chip select goes low. The result then comes back during one 16-clock read, so the conversion time is the read itself. Every frame starts with four zero bits, followed by a two's-complement word sent most significant bit first.

The reader runs from a fast system clock. A programmable divider sets the length of each serial clock phase in system cycles. A start pulse is latched as a pending request. The reader issues it as soon as the link is free. It lowers chip select, makes sixteen serial clock periods and captures one bit in each. It then raises chip select and presents the signed result with a one-cycle strobe, provided the four leading bits were zero.

Between frames the reader holds chip select high for a programmed quiet gap. A power-down request parks the link idle. Leaving that state costs a programmed wake delay before the next conversion can start.

Top module: `sar_frame_reader`

## Requirements
- R1: While reset is held, chip select and serial clock are high, and busy, result-valid and frame-error are low.
- R2: Chip select falls only while the serial clock is high, and it falls only when a start request is pending.
- R3: Every serial clock phase, including the setup phase from the chip-select fall to the first clock fall, lasts exactly `cfg_half_div` system cycles (0 is treated as 1).
- R4: The serial clock stays high whenever chip select is high, and each frame contains exactly 16 serial clock falling edges.
- R5: Each bit is captured on the system edge that drives the serial clock low. The first capture is bit 15 and the last is bit 0. Bits 11..0 form the result as a signed two's-complement value. `valid_o` pulses for one cycle in the cycle in which chip select returns high, and `result_o` changes only with that pulse.
- R6: If any of frame bits 15..12 is 1, no valid pulse is issued and `result_o` keeps its previous value. `frame_err_o` is then set, and it stays set until reset.
- R7: After a frame, chip select stays high for at least `cfg_quiet + 1` system cycles before it falls again.
- R8: A start pulse seen during a frame, a quiet gap or a wake wait is held as one pending request. Any number of pulses in that window gives exactly one further frame.
- R9: While `pwr_down_i` is high and the link is idle, no frame starts, but a start request stays pending. After release, chip select does not fall for at least `cfg_wake + 1` cycles. The pending frame is then issued.
- R10: A power-down request raised during a frame does not abort it; the frame completes with its valid result.
- R11: `busy_o` is high for the whole time chip select is low, through the quiet gap and during the wake wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request for a conversion |
| pwr_down_i | input | 1 | Hold the link in the power-down idle state |
| cfg_half_div | input | DIV_W | System cycles per serial clock phase |
| cfg_quiet | input | GAP_W | Quiet gap length between frames |
| cfg_wake | input | GAP_W | Wake delay after leaving power-down |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | Frame, quiet gap or wake wait in progress |
| result_o | output | DATA_W | Signed conversion result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| frame_err_o | output | 1 | Sticky flag for a nonzero leading bit |

## Verification
The bench builds the reader with its default parameters: a 12-bit word, four leading bits, an 8-bit divider and 12-bit gap counters. It then varies the runtime configuration across serial clock phases of one, two and three system cycles and quiet gaps of zero and three cycles. The one-cycle phase exercises the tightest timing, where every tick toggles the clock. The zero gap exercises the case where the minimum chip-select high time comes from the state sequencing alone. A wake delay of twenty cycles is long enough that an early chip-select fall after power-down stands out clearly against the measured delay.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_GAP,
    ST_SLEEP,
    ST_WAKE
  } rd_state_t;

endpackage

// File: rtl/sar_half_div.sv
// Phase tick generator: one tick every half_i system cycles while run_i.
module sar_half_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_m1;

  assign half_m1 = (half_i == '0) ? '0 : half_i - 1'b1;
  assign tick_o  = run_i && (cnt_q == half_m1);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: the phase counter never runs past the programmed phase length
  a_r3_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt_q <= half_m1));

endmodule

// File: rtl/sar_gap_timer.sv
// Down counter for the quiet gap and the wake delay.
module sar_gap_timer #(
  parameter int GAP_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [GAP_W-1:0] val_i,
  input  logic             en_i,
  output logic             expired_o
);

  logic [GAP_W-1:0] cnt_q;

  assign expired_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (en_i && !expired_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7: the count only moves downward unless it is reloaded
  a_r7_timer_down: assert property (@(posedge clk) disable iff (rst)
    !$past(load_i) && $past(cnt_q) == '0 |-> cnt_q == '0);

endmodule

// File: rtl/sar_frame_shift.sv
// Frame capture register: MSB first, leading-bit check.
module sar_frame_shift #(
  parameter int LEAD_W = 4,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              lead_ok_o
);

  localparam int FRAME_W = LEAD_W + DATA_W;

  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (shift_i) begin
      sr_q <= {sr_q[FRAME_W-2:0], bit_i};
    end
  end

  assign data_o    = sr_q[DATA_W-1:0];
  assign lead_ok_o = (sr_q[FRAME_W-1:DATA_W] == '0);

endmodule

// File: rtl/sar_frame_reader.sv
module sar_frame_reader
  import sar_rd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LEAD_W = 4,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic                     pwr_down_i,
  input  logic [DIV_W-1:0]         cfg_half_div,
  input  logic [GAP_W-1:0]         cfg_quiet,
  input  logic [GAP_W-1:0]         cfg_wake,
  input  logic                     sdata_i,
  output logic                     cs_n_o,
  output logic                     sclk_o,
  output logic                     busy_o,
  output logic signed [DATA_W-1:0] result_o,
  output logic                     valid_o,
  output logic                     frame_err_o
);

  localparam int FRAME_LEN = LEAD_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int HI_W      = GAP_W + 2;

  rd_state_t         st_q, st_d;
  logic              cs_q, cs_d;
  logic              sclk_q, sclk_d;
  logic              pend_q, pend_d;
  logic [CNT_W-1:0]  nfall_q, nfall_d;
  logic              tick;
  logic              shift_en;
  logic              fin;
  logic              tmr_load;
  logic [GAP_W-1:0]  tmr_val;
  logic              tmr_exp;
  logic [DATA_W-1:0] cap_data;
  logic              cap_ok;

  sar_half_div #(.DIV_W(DIV_W)) i_div (
    .clk    (clk),
    .rst    (rst),
    .run_i  (st_q == ST_FRAME),
    .half_i (cfg_half_div),
    .tick_o (tick)
  );

  sar_gap_timer #(.GAP_W(GAP_W)) i_gap (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .en_i      ((st_q == ST_GAP) || (st_q == ST_WAKE)),
    .expired_o (tmr_exp)
  );

  sar_frame_shift #(.LEAD_W(LEAD_W), .DATA_W(DATA_W)) i_shift (
    .clk       (clk),
    .rst       (rst),
    .shift_i   (shift_en),
    .bit_i     (sdata_i),
    .data_o    (cap_data),
    .lead_ok_o (cap_ok)
  );

  always_comb begin
    st_d     = st_q;
    cs_d     = cs_q;
    sclk_d   = sclk_q;
    nfall_d  = nfall_q;
    pend_d   = pend_q | start_i;
    tmr_load = 1'b0;
    tmr_val  = cfg_quiet;
    shift_en = 1'b0;
    fin      = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (pwr_down_i) begin
          st_d = ST_SLEEP;
        end else if (pend_q) begin
          st_d    = ST_FRAME;
          cs_d    = 1'b0;
          pend_d  = start_i;
          nfall_d = '0;
        end
      end
      ST_FRAME: begin
        if (tick) begin
          if (sclk_q) begin
            sclk_d   = 1'b0;
            shift_en = 1'b1;
            nfall_d  = nfall_q + 1'b1;
          end else if (nfall_q == CNT_W'(FRAME_LEN)) begin
            sclk_d   = 1'b1;
            cs_d     = 1'b1;
            fin      = 1'b1;
            tmr_load = 1'b1;
            st_d     = ST_GAP;
          end else begin
            sclk_d = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (tmr_exp) st_d = ST_IDLE;
      end
      ST_SLEEP: begin
        if (!pwr_down_i) begin
          tmr_load = 1'b1;
          tmr_val  = cfg_wake;
          st_d     = ST_WAKE;
        end
      end
      ST_WAKE: begin
        if (tmr_exp) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      cs_q        <= 1'b1;
      sclk_q      <= 1'b1;
      pend_q      <= 1'b0;
      nfall_q     <= '0;
      valid_o     <= 1'b0;
      result_o    <= '0;
      frame_err_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      cs_q    <= cs_d;
      sclk_q  <= sclk_d;
      pend_q  <= pend_d;
      nfall_q <= nfall_d;
      valid_o <= fin && cap_ok;
      if (fin && cap_ok) result_o <= $signed(cap_data);
      if (fin && !cap_ok) frame_err_o <= 1'b1;
    end
  end

  assign cs_n_o = cs_q;
  assign sclk_o = sclk_q;
  assign busy_o = (st_q == ST_FRAME) || (st_q == ST_GAP) || (st_q == ST_WAKE);

  // Checker state: cycles chip select has been high, saturating.
  logic [HI_W-1:0] hi_cnt_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt_q <= '1;
    end else if (!cs_q) begin
      hi_cnt_q <= '0;
    end else if (hi_cnt_q != '1) begin
      hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  // R2: chip select falls only with the serial clock high
  a_r2_cs_fall_clk_high: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> sclk_o);

  // R4: serial clock idles high outside a frame
  a_r4_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> sclk_o);

  // R4: never more falls than the frame holds
  a_r4_no_overrun: assert property (@(posedge clk) disable iff (rst)
    nfall_q <= CNT_W'(FRAME_LEN));

  // R5: the strobe coincides with the end of a frame
  a_r5_valid_at_end: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $rose(cs_n_o));

  // R5: the result changes only with the strobe
  a_r5_result_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(result_o));

  // R6: the frame error flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(frame_err_o) |-> frame_err_o);

  // R7: minimum chip-select high time before the next fall
  a_r7_quiet_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> (hi_cnt_q > HI_W'(cfg_quiet)));

  // R11: busy covers every cycle chip select is low
  a_r11_busy_in_frame: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> busy_o);

endmodule

// File: tb/test_sar_frame_reader.sv
module test_sar_frame_reader;

  localparam int DATA_W = 12;
  localparam int LEAD_W = 4;
  localparam int DIV_W  = 8;
  localparam int GAP_W  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic pwr_down_i = 1'b0;
  logic [DIV_W-1:0] cfg_half_div = 8'd2;
  logic [GAP_W-1:0] cfg_quiet = 12'd3;
  logic [GAP_W-1:0] cfg_wake = 12'd20;
  logic sdata_i = 1'b1;
  logic cs_n_o, sclk_o, busy_o, valid_o, frame_err_o;
  logic signed [DATA_W-1:0] result_o;

  always #10 clk = ~clk;

  sar_frame_reader #(.DATA_W(DATA_W), .LEAD_W(LEAD_W), .DIV_W(DIV_W), .GAP_W(GAP_W)) i_sar_frame_reader (
    .clk(clk), .rst(rst), .start_i(start_i), .pwr_down_i(pwr_down_i),
    .cfg_half_div(cfg_half_div), .cfg_quiet(cfg_quiet), .cfg_wake(cfg_wake),
    .sdata_i(sdata_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .busy_o(busy_o),
    .result_o(result_o), .valid_o(valid_o), .frame_err_o(frame_err_o)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sext12(input logic [15:0] w);
    int v;
    v = int'(w[11:0]);
    if (v >= 2048) v -= 4096;
    return v;
  endfunction

  // Converter model and per-clock reference
  logic [15:0] word_q[$];
  int          exp_q[$];
  logic [15:0] cur_word = 16'hFFFF;
  int  nfalls = 0, seg = 0, hi_len = 1000000;
  int  frames = 0, n_valid = 0;
  bit  bad_timing = 0, busy_bad = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;

  always @(negedge clk) begin
    if (rst) begin
      prev_cs = 1'b1; prev_sclk = 1'b1; hi_len = 1000000;
      sdata_i = 1'b1;
    end else begin
      if (!cs_n_o && !busy_o) busy_bad = 1;
      if (prev_cs && !cs_n_o) begin
        frames++;
        check(hi_len >= int'(cfg_quiet) + 1, "R7 cs high time", hi_len, int'(cfg_quiet) + 1);
        check(sclk_o == 1'b1, "R2 sclk at cs fall", int'(sclk_o), 1);
        cur_word = (word_q.size() > 0) ? word_q.pop_front() : 16'h0000;
        if (cur_word[15:12] == 4'h0) exp_q.push_back(sext12(cur_word));
        nfalls = 0; seg = 0; bad_timing = 0; busy_bad = 0;
      end else if (!prev_cs) begin
        if (sclk_o != prev_sclk) begin
          if (seg + 1 != int'(cfg_half_div)) bad_timing = 1;
          seg = 0;
          if (!sclk_o) nfalls++;
        end else begin
          seg++;
        end
        if (cs_n_o) begin
          check(!bad_timing, "R3 phase length", int'(bad_timing), 0);
          check(nfalls == 16, "R4 falls per frame", nfalls, 16);
          check(!busy_bad, "R11 busy during frame", int'(busy_bad), 0);
        end
      end
      if (cs_n_o && !sclk_o) check(0, "R4 sclk low with cs high", 0, 1);
      if (valid_o) begin
        n_valid++;
        if (exp_q.size() == 0) check(0, "R5 unexpected valid", int'(result_o), 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(int'(result_o) == e, "R5 result value", int'(result_o), e);
        end
      end
      if (cs_n_o) hi_len++; else hi_len = 0;
      sdata_i = cs_n_o ? 1'b1 : ((nfalls < 16) ? cur_word[15 - nfalls] : 1'b1);
      prev_cs = cs_n_o; prev_sclk = sclk_o;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet_run;
    quiet_run = 0;
    while (quiet_run < 6) begin
      @(negedge clk);
      if (!busy_o && cs_n_o) quiet_run++; else quiet_run = 0;
    end
  endtask

  task automatic run_frame(input logic [15:0] w);
    word_q.push_back(w);
    pulse_start();
    wait_idle();
  endtask

  initial begin
    int f0, v0, waited;
    logic signed [DATA_W-1:0] held;
    repeat (4) @(negedge clk);
    check(cs_n_o == 1'b1, "R1 cs_n in reset", int'(cs_n_o), 1);
    check(sclk_o == 1'b1, "R1 sclk in reset", int'(sclk_o), 1);
    check(busy_o == 1'b0, "R1 busy in reset", int'(busy_o), 0);
    check(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
    check(frame_err_o == 1'b0, "R1 error in reset", int'(frame_err_o), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R5 signed values, two-cycle phases
    run_frame(16'h0123);
    run_frame(16'h0800);
    run_frame(16'h07FF);
    run_frame(16'h0FFF);

    // R3 single-cycle phases, zero quiet gap
    cfg_half_div = 8'd1; cfg_quiet = 12'd0;
    run_frame(16'h0A5A);
    run_frame(16'h0001);

    // R6 leading-bit error
    cfg_half_div = 8'd3; cfg_quiet = 12'd3;
    v0 = n_valid; held = result_o;
    run_frame(16'h4123);
    check(frame_err_o == 1'b1, "R6 error flag set", int'(frame_err_o), 1);
    check(n_valid == v0, "R6 no valid on error", n_valid, v0);
    check(result_o == held, "R6 result held", int'(result_o), int'(held));
    run_frame(16'h0456);
    check(frame_err_o == 1'b1, "R6 error flag sticky", int'(frame_err_o), 1);
    check(n_valid == v0 + 1, "R6 good frame after error", n_valid, v0 + 1);

    // R8 starts while busy collapse into one pending frame
    cfg_half_div = 8'd2;
    f0 = frames;
    word_q.push_back(16'h0111);
    word_q.push_back(16'h0222);
    pulse_start();
    while (cs_n_o) @(negedge clk);
    pulse_start();
    pulse_start();
    wait_idle();
    check(frames == f0 + 2, "R8 one extra frame", frames - f0, 2);

    // R9 power-down holds a start, then wake delay
    @(negedge clk) pwr_down_i = 1'b1;
    repeat (2) @(negedge clk);
    f0 = frames;
    word_q.push_back(16'h0333);
    pulse_start();
    repeat (60) @(negedge clk);
    check(frames == f0, "R9 no frame in power-down", frames - f0, 0);
    @(negedge clk) pwr_down_i = 1'b0;
    waited = 0;
    while (cs_n_o && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
    check(waited >= int'(cfg_wake) + 1, "R9 wake delay", waited, int'(cfg_wake) + 1);
    wait_idle();
    check(frames == f0 + 1, "R9 pending frame issued", frames - f0, 1);

    // R10 power-down during a frame does not abort it
    v0 = n_valid;
    word_q.push_back(16'h0444);
    pulse_start();
    while (cs_n_o) @(negedge clk);
    repeat (5) @(negedge clk);
    pwr_down_i = 1'b1;
    while (!cs_n_o) @(negedge clk);
    repeat (3) @(negedge clk);
    check(n_valid == v0 + 1, "R10 frame completed", n_valid - v0, 1);
    repeat (10) @(negedge clk);
    pwr_down_i = 1'b0;
    wait_idle();

    check(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule